// File: doc/BRIEF.md
# Masked Vector Element Executor

This block holds a small set of vector registers and a one-bit-per-element mask, and it runs element-wise operations on them under that mask. Two commands work on the mask: one sets every mask bit, and one builds the mask by comparing each element of a source register against a scalar. Two commands work on the data: a masked copy and a masked add from source registers into a destination register. A host port loads and reads single elements of any register.

Each element command selects one of two execution modes. In the simple mode the block steps through every element below the active length, one per cycle, and lets only those with a set mask bit write back. In the dense mode it first combines the mask with the active length and then visits only the set positions. Its run time therefore follows the number of active elements rather than the vector length. In both modes a destination element that is not written keeps its old contents. A busy flag covers the whole run, and no new command or host write is taken while it is high.

Top module: `mvx_exec`

## Requirements
- R1: After reset, and after an accepted mask-clear command (`cmd_op` = 2'b00), `mask_out` is all ones. A mask command takes effect at the edge that accepts it and never raises `busy`.
- R2: An accepted compare command (`cmd_op` = 2'b01) sets mask bit i when element i of register `cmd_src_a` is greater than `cmd_scalar` (unsigned) and i < `cmd_len`. Every other mask bit is cleared.
- R3: In simple mode (`cmd_dense` = 0) an element command visits elements 0 to len-1 in ascending order, one per cycle. `wb_valid` is high on a visit only when that element's mask bit is set. `busy` is high for len+1 cycles.
- R4: In dense mode (`cmd_dense` = 1) only the elements below len whose mask bit is set are visited, in ascending order, one per cycle. `busy` is high for the number of such elements plus one cycle, so an empty selection takes exactly one cycle.
- R5: A destination element whose mask bit is clear keeps its previous value in both modes.
- R6: Destination elements at or above `cmd_len` are never written. A `cmd_len` larger than the element count acts as the full count.
- R7: Copy (`cmd_op` = 2'b10) writes element i of `cmd_src_a`. Add (`cmd_op` = 2'b11) writes element i of `cmd_src_a` plus element i of `cmd_src_b`, modulo 2^DATA_W. The value and index of each write appear on `wb_data` and `wb_idx` in the cycle before the write.
- R8: A command is accepted on a rising edge where `cmd_valid` is high and `busy` is low. `busy` rises on the edge after an element command is accepted and stays high until the cycle after the last visit. Commands presented while busy are ignored, and the mask does not change during a run.
- R9: The host port writes one element when `host_we` is high and `busy` is low; a host write while busy is dropped. `rd_data` returns element `rd_idx` of register `rd_reg` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 mask clear, 01 compare, 10 copy, 11 add |
| cmd_dst | input | REG_W | Destination register |
| cmd_src_a | input | REG_W | First source register (also the compare source) |
| cmd_src_b | input | REG_W | Second source register for add |
| cmd_scalar | input | DATA_W | Compare operand |
| cmd_len | input | LEN_W | Active vector length |
| cmd_dense | input | 1 | 1 selects dense mode, 0 simple mode |
| busy | output | 1 | An element command is running |
| host_we | input | 1 | Host element write |
| host_reg | input | REG_W | Host write register |
| host_idx | input | IDX_W | Host write element |
| host_wdata | input | DATA_W | Host write value |
| rd_reg | input | REG_W | Read register |
| rd_idx | input | IDX_W | Read element |
| rd_data | output | DATA_W | Read value |
| mask_out | output | NUM_ELEM | Current mask |
| wb_valid | output | 1 | An element is written at the next edge |
| wb_idx | output | IDX_W | Element being written |
| wb_data | output | DATA_W | Value being written |

## Verification
The element commands are run with a full mask, with an alternating mask built by compare, with a mask clipped by a short compare length, and with an empty mask. Together these separate writeback gating from element skipping and show whether the run length follows the length or the mask population. Lengths of zero, a partial length, the full count and an oversized value check the length handling. An add whose sums overflow checks the modular arithmetic. One run is given a competing command and a host write while busy, and both must leave no trace.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic [1:0] {
    OP_MCLR = 2'b00,
    OP_MCMP = 2'b01,
    OP_COPY = 2'b10,
    OP_ADD  = 2'b11
  } mvx_op_e;
endpackage

// File: rtl/mvx_regfile.sv
module mvx_regfile #(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_VREG = 4,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int REG_W   = $clog2(NUM_VREG)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [REG_W-1:0]           wr_reg,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [REG_W-1:0]           ra_reg,
  input  logic [IDX_W-1:0]           ra_idx,
  output logic [DATA_W-1:0]          ra_data,
  input  logic [REG_W-1:0]           rb_reg,
  input  logic [IDX_W-1:0]           rb_idx,
  output logic [DATA_W-1:0]          rb_data,
  input  logic [REG_W-1:0]           rh_reg,
  input  logic [IDX_W-1:0]           rh_idx,
  output logic [DATA_W-1:0]          rh_data,
  input  logic [REG_W-1:0]           rv_reg,
  output logic [NUM_ELEM*DATA_W-1:0] rv_vec
);
  logic [DATA_W-1:0] mem [NUM_VREG][NUM_ELEM];

  // data storage carries no reset; contents are defined by host loads
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_reg][wr_idx] <= wr_data;
    end
  end

  assign ra_data = mem[ra_reg][ra_idx];
  assign rb_data = mem[rb_reg][rb_idx];
  assign rh_data = mem[rh_reg][rh_idx];

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_vec
    assign rv_vec[e*DATA_W +: DATA_W] = mem[rv_reg][e];
  end
endmodule

// File: rtl/mvx_mask_unit.sv
module mvx_mask_unit #(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_en,
  input  logic                       cmp_en,
  input  logic [NUM_ELEM*DATA_W-1:0] cmp_vec,
  input  logic [DATA_W-1:0]          cmp_scalar,
  input  logic [NUM_ELEM-1:0]        len_mask,
  output logic [NUM_ELEM-1:0]        mask_q
);
  logic [NUM_ELEM-1:0] mask_d;
  logic [NUM_ELEM-1:0] cmp_hit;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_cmp
    assign cmp_hit[e] = len_mask[e] && (cmp_vec[e*DATA_W +: DATA_W] > cmp_scalar);
  end

  always_comb begin
    mask_d = mask_q;
    if (clr_en) begin
      mask_d = '1;
    end else if (cmp_en) begin
      mask_d = cmp_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (clr_en || cmp_en) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/mvx_seq.sv
module mvx_seq #(
  parameter int NUM_ELEM = 8,
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                dense_in,
  input  logic [NUM_ELEM-1:0] len_mask,
  input  logic [NUM_ELEM-1:0] mask,
  output logic                busy_q,
  output logic                dense_q,
  output logic                elem_valid,
  output logic [IDX_W-1:0]    elem_idx
);
  logic [NUM_ELEM-1:0] pend_q, pend_d;
  logic [NUM_ELEM-1:0] low_onehot;
  logic                busy_d;
  logic                any_pend;

  assign any_pend = |pend_q;

  always_comb begin
    elem_idx = '0;
    for (int i = NUM_ELEM - 1; i >= 0; i--) begin
      if (pend_q[i]) elem_idx = IDX_W'(i);
    end
  end

  assign low_onehot = any_pend ? (NUM_ELEM'(1) << elem_idx) : '0;
  assign elem_valid = busy_q && any_pend;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (start) begin
      pend_d = dense_in ? (mask & len_mask) : len_mask;
      busy_d = 1'b1;
    end else if (busy_q) begin
      pend_d = pend_q & ~low_onehot;
      busy_d = any_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pend_q  <= '0;
      dense_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (start || busy_q) begin
        pend_q <= pend_d;
      end
      if (start) begin
        dense_q <= dense_in;
      end
    end
  end
endmodule

// File: rtl/mvx_exec.sv
module mvx_exec #(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_VREG = 4,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int REG_W   = $clog2(NUM_VREG),
  localparam int LEN_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [REG_W-1:0]    cmd_dst,
  input  logic [REG_W-1:0]    cmd_src_a,
  input  logic [REG_W-1:0]    cmd_src_b,
  input  logic [DATA_W-1:0]   cmd_scalar,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic                cmd_dense,
  output logic                busy,
  input  logic                host_we,
  input  logic [REG_W-1:0]    host_reg,
  input  logic [IDX_W-1:0]    host_idx,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [REG_W-1:0]    rd_reg,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_ELEM-1:0] mask_out,
  output logic                wb_valid,
  output logic [IDX_W-1:0]    wb_idx,
  output logic [DATA_W-1:0]   wb_data
);
  import mvx_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mvx_op_e             op_in;
  logic                accept;
  logic                start_elem;
  logic [NUM_ELEM-1:0] len_mask;

  assign op_in      = mvx_op_e'(cmd_op);
  assign accept     = cmd_valid && !busy;
  assign start_elem = accept && ((op_in == OP_COPY) || (op_in == OP_ADD));

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_len
    assign len_mask[e] = LEN_W'(e) < cmd_len;
  end

  // latched element command
  mvx_op_e          op_q;
  logic [REG_W-1:0] dst_q, src_a_q, src_b_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q    <= OP_COPY;
      dst_q   <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
    end else if (start_elem) begin
      op_q    <= op_in;
      dst_q   <= cmd_dst;
      src_a_q <= cmd_src_a;
      src_b_q <= cmd_src_b;
    end
  end

  logic [NUM_ELEM-1:0] mask_q;
  logic                seq_dense;
  logic                elem_valid;
  logic [IDX_W-1:0]    elem_idx;

  mvx_seq #(.NUM_ELEM(NUM_ELEM)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start_elem),
    .dense_in   (cmd_dense),
    .len_mask   (len_mask),
    .mask       (mask_q),
    .busy_q     (busy),
    .dense_q    (seq_dense),
    .elem_valid (elem_valid),
    .elem_idx   (elem_idx)
  );

  logic [NUM_ELEM*DATA_W-1:0] cmp_vec;

  mvx_mask_unit #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W)) u_mask (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_en     (accept && (op_in == OP_MCLR)),
    .cmp_en     (accept && (op_in == OP_MCMP)),
    .cmp_vec    (cmp_vec),
    .cmp_scalar (cmd_scalar),
    .len_mask   (len_mask),
    .mask_q     (mask_q)
  );

  logic                wb_fire;
  logic [DATA_W-1:0]   a_elem, b_elem, wb_val;
  logic                rf_we;
  logic [REG_W-1:0]    rf_wreg;
  logic [IDX_W-1:0]    rf_widx;
  logic [DATA_W-1:0]   rf_wdata;

  assign wb_fire  = elem_valid && mask_q[elem_idx];
  assign wb_val   = (op_q == OP_ADD) ? (a_elem + b_elem) : a_elem;

  // engine writes only while busy; host writes only while idle
  assign rf_we    = wb_fire || (host_we && !busy);
  assign rf_wreg  = wb_fire ? dst_q    : host_reg;
  assign rf_widx  = wb_fire ? elem_idx : host_idx;
  assign rf_wdata = wb_fire ? wb_val   : host_wdata;

  mvx_regfile #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W), .NUM_VREG(NUM_VREG)) u_rf (
    .clk     (clk),
    .wr_en   (rf_we),
    .wr_reg  (rf_wreg),
    .wr_idx  (rf_widx),
    .wr_data (rf_wdata),
    .ra_reg  (src_a_q),
    .ra_idx  (elem_idx),
    .ra_data (a_elem),
    .rb_reg  (src_b_q),
    .rb_idx  (elem_idx),
    .rb_data (b_elem),
    .rh_reg  (rd_reg),
    .rh_idx  (rd_idx),
    .rh_data (rd_data),
    .rv_reg  (cmd_src_a),
    .rv_vec  (cmp_vec)
  );

  assign mask_out = mask_q;
  assign wb_valid = wb_fire;
  assign wb_idx   = elem_idx;
  assign wb_data  = wb_val;
endmodule

// File: rtl/mvx_exec_chk.sv
module mvx_exec_chk #(
  parameter int NUM_ELEM = 8,
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                busy,
  input logic                wb_valid,
  input logic [IDX_W-1:0]    wb_idx,
  input logic [NUM_ELEM-1:0] mask_out,
  input logic                dense_q
);
  a_r3_write_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mask_out[wb_idx]);

  a_r8_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);

  a_r8_busy_from_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  a_r8_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_out));

  a_r3_ascending_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $past(wb_valid)) |-> (wb_idx > $past(wb_idx)));

  a_r4_dense_no_idle_visit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dense_q && !wb_valid) |=> !busy);
endmodule

bind mvx_exec mvx_exec_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .wb_valid  (wb_valid),
  .wb_idx    (wb_idx),
  .mask_out  (mask_out),
  .dense_q   (seq_dense)
);

// File: tb/mvx_exec_bench.sv
`timescale 1ns/1ps
module mvx_exec_bench;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int R  = 4;
  localparam int IW = 3;
  localparam int LW = 4;
  localparam int RW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [RW-1:0] cmd_dst, cmd_src_a, cmd_src_b;
  logic [W-1:0]  cmd_scalar;
  logic [LW-1:0] cmd_len;
  logic          cmd_dense;
  logic          busy;
  logic          host_we;
  logic [RW-1:0] host_reg;
  logic [IW-1:0] host_idx;
  logic [W-1:0]  host_wdata;
  logic [RW-1:0] rd_reg;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  rd_data;
  logic [N-1:0]  mask_out;
  logic          wb_valid;
  logic [IW-1:0] wb_idx;
  logic [W-1:0]  wb_data;

  mvx_exec #(.NUM_ELEM(N), .DATA_W(W), .NUM_VREG(R)) u_mvx_exec (.*);

  logic [W-1:0]    mdl_reg [R][N];
  logic [N-1:0]    mdl_mask;
  logic [IW+W-1:0] exp_q [$];
  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every writeback must match the next expected item
  always @(negedge clk) begin
    if (rst_n === 1'b1 && wb_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected write", {16'h0, wb_idx, wb_data[W-4:0]}, 32'h0);
      end else begin
        logic [IW+W-1:0] item;
        item = exp_q.pop_front();
        chk({wb_idx, wb_data} == item, "R7 writeback idx/data", 32'({wb_idx, wb_data}), 32'(item));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic load_vec(input int r, input logic [W-1:0] v [N]);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_reg = RW'(r); host_idx = IW'(i); host_wdata = v[i];
      mdl_reg[r][i] = v[i];
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic read_el(input int r, input int i, output logic [W-1:0] d);
    rd_reg = RW'(r); rd_idx = IW'(i);
    #1 d = rd_data;
  endtask

  task automatic mask_cmd(input logic [1:0] op, input int src, input logic [W-1:0] sc, input int len, input string req);
    for (int i = 0; i < N; i++) begin
      if (op == 2'b00) mdl_mask[i] = 1'b1;
      else mdl_mask[i] = (i < len) && (mdl_reg[src][i] > sc);
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_src_a = RW'(src); cmd_scalar = sc; cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(mask_out == mdl_mask, req, 32'(mask_out), 32'(mdl_mask));
    chk(busy == 1'b0, "R1 mask command leaves busy low", 32'(busy), 32'h0);
  endtask

  task automatic run_op(input logic [1:0] op, input int dst, input int a, input int b,
                        input int len, input bit dense, input bit poke);
    int eff, cnt_exp, cnt;
    logic [W-1:0] v, d;
    eff = (len > N) ? N : len;
    cnt_exp = 1;
    for (int i = 0; i < eff; i++) begin
      if (!dense || mdl_mask[i]) cnt_exp++;
      if (mdl_mask[i]) begin
        v = (op == 2'b11) ? W'(mdl_reg[a][i] + mdl_reg[b][i]) : mdl_reg[a][i];
        exp_q.push_back({IW'(i), v});
        mdl_reg[dst][i] = v;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dst = RW'(dst); cmd_src_a = RW'(a);
    cmd_src_b = RW'(b); cmd_len = LW'(len); cmd_dense = dense;
    @(negedge clk);
    if (poke) begin
      cmd_op = 2'b01; cmd_src_a = RW'(a); cmd_scalar = 16'hFFFF; cmd_len = LW'(N);
      host_we = 1'b1; host_reg = 2'd3; host_idx = '0; host_wdata = 16'hDEAD;
    end else begin
      cmd_valid = 1'b0;
    end
    cnt = 0;
    while (busy === 1'b1 && cnt < 100) begin
      cnt++;
      @(negedge clk);
      if (cnt == 1) begin cmd_valid = 1'b0; host_we = 1'b0; end
    end
    chk(cnt == cnt_exp, dense ? "R4 busy cycles" : "R3 busy cycles", 32'(cnt), 32'(cnt_exp));
    chk(exp_q.size() == 0, "R7 all expected writes seen", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    for (int i = 0; i < N; i++) begin
      read_el(dst, i, d);
      chk(d == mdl_reg[dst][i], (i < eff) ? "R5 destination readback" : "R6 beyond length untouched",
          32'(d), 32'(mdl_reg[dst][i]));
    end
    if (poke) begin
      read_el(3, 0, d);
      chk(d == mdl_reg[3][0], "R9 host write while busy dropped", 32'(d), 32'(mdl_reg[3][0]));
      chk(mask_out == mdl_mask, "R8 command while busy ignored", 32'(mask_out), 32'(mdl_mask));
    end
  endtask

  initial begin
    logic [W-1:0] va [N];
    logic [W-1:0] vb [N];
    logic [W-1:0] vc [N];
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_dst = '0; cmd_src_a = '0;
    cmd_src_b = '0; cmd_scalar = '0; cmd_len = '0; cmd_dense = 1'b0;
    host_we = 1'b0; host_reg = '0; host_idx = '0; host_wdata = '0;
    rd_reg = '0; rd_idx = '0;
    mdl_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(busy == 1'b0, "R8 busy low after reset", 32'(busy), 32'h0);
    chk(wb_valid == 1'b0, "R8 no write after reset", 32'(wb_valid), 32'h0);
    chk(mask_out == '1, "R1 mask all ones after reset", 32'(mask_out), 32'hFF);

    va = '{16'd5, 16'd50, 16'd7, 16'd90, 16'd3, 16'd60, 16'd2, 16'd80};
    vb = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8};
    vc = '{16'hFFF0, 16'hFFFF, 16'h8000, 16'hFFFE, 16'h0001, 16'hFFC0, 16'h7FFF, 16'hFF00};
    load_vec(0, va);
    load_vec(1, vb);
    load_vec(2, vc);
    load_vec(3, vb);

    // R3 R7: simple copy with full mask
    mask_cmd(2'b00, 0, '0, 0, "R1 mask clear");
    run_op(2'b10, 2, 0, 0, 8, 1'b0, 1'b0);
    // R2: alternating mask
    mask_cmd(2'b01, 0, 16'd40, 8, "R2 compare full length");
    // R3 R5: simple add, odd elements only
    load_vec(2, vc);
    run_op(2'b11, 2, 0, 1, 8, 1'b0, 1'b0);
    // R4: dense add, four active elements
    run_op(2'b11, 3, 0, 1, 8, 1'b1, 1'b0);
    // R4 R6: dense with partial length
    load_vec(3, vc);
    run_op(2'b10, 3, 1, 1, 4, 1'b1, 1'b0);
    // R2: compare with short length clears upper bits
    mask_cmd(2'b01, 0, 16'd4, 5, "R2 compare short length");
    run_op(2'b10, 2, 1, 1, 8, 1'b0, 1'b0);
    // R4: empty mask in dense mode takes one cycle
    mask_cmd(2'b01, 0, 16'hFFFF, 8, "R2 compare empty mask");
    run_op(2'b11, 2, 0, 1, 8, 1'b1, 1'b0);
    // R6 R7: oversized length and modular add
    mask_cmd(2'b00, 0, '0, 0, "R1 mask clear again");
    run_op(2'b11, 1, 2, 1, 15, 1'b0, 1'b0);
    // R6: zero length
    run_op(2'b10, 3, 0, 0, 0, 1'b0, 1'b0);
    // R8 R9: competing command and host write while busy
    run_op(2'b10, 2, 0, 0, 8, 1'b0, 1'b1);
    // R4 dense with full mask behaves like simple timing
    run_op(2'b11, 2, 0, 0, 8, 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule